// File: doc/BRIEF.md
# Overcurrent Pulse-Skip and Latch Sequencer

This block sits between a cycle-by-cycle current-limit comparator and the high-side gate driver of a synchronous buck converter. It runs on the switching-cycle clock, so one clock period is one converter cycle. While the comparator reports an overcurrent, the block blocks the high-side drive request and the converter skips pulses. The first trip also starts a cycle count.

The count is split into two windows. During the first window, a trip only causes pulse skipping. A trip during the second window means the overload is sustained. The block then latches the converter off and asks the supervisor to drop power-good. If the second window passes with no trip, the sequencer returns to idle by itself. Only a fault-clear request, a low enable or the asynchronous reset releases a latched fault.

Top module: `ocp_skip_latch`

## Requirements
- R1: While enable is high and the limit-detect input is high, the high-side inhibit output is high in the same cycle. Pulses are skipped without any clock delay.
- R2: A trip taken while idle marks cycle 0 of a sequence. Further trips in cycles 0 to SKIP_LEN-1 neither latch the fault nor restart the count.
- R3: A trip in any cycle from SKIP_LEN to SKIP_LEN+WATCH_LEN-1 after the first trip sets the latched-fault output from the next cycle. This covers both the first and the last cycle of that window.
- R4: If no trip occurs in the second window, the sequencer is idle again at cycle SKIP_LEN+WATCH_LEN. A trip in that cycle starts a new sequence and does not latch. The cycle counter never exceeds SKIP_LEN+WATCH_LEN-1.
- R5: While the fault is latched, both the high-side inhibit output and the power-good drop output are high.
- R6: A latched fault holds until a fault-clear request or a low enable is sampled. All outputs are low in the following cycle, provided the limit-detect input is low.
- R7: While enable is low, the limit-detect input is ignored. The inhibit stays low and no sequence starts. Dropping enable in mid-sequence abandons that sequence.
- R8: The active-low asynchronous reset clears the latched fault and the sequence state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Switching-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low (power-on reset) |
| en_i | input | 1 | Converter enable; low disables and clears a latched fault |
| lim_det_i | input | 1 | Current-limit detect from the analog comparator |
| fault_clr_i | input | 1 | Request to clear a latched fault |
| hs_inhibit_o | output | 1 | Suppress the high-side drive request |
| fault_latched_o | output | 1 | Converter latched off by overcurrent |
| pgood_drop_o | output | 1 | Request to force power-good low |

## Verification
The bench builds the block with its default values: an 8-cycle skip window, an 8-cycle watch window and a 5-bit counter. With these values the whole 16-cycle sequence fits inside the vector table. This makes each edge case a single row: a trip in the last skip cycle, trips in the first and last watch cycles, and a trip in the cycle where the sequence auto-clears. The vectors also cover a trip during enable low, followed by a trip eight cycles later. That pair shows whether the disabled trip started a sequence. Directed tests cover an enable drop in mid-sequence and an asynchronous reset while the fault is latched.

// File: rtl/ocp_seq_pkg.sv
package ocp_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SKIP  = 2'd1,
    ST_WATCH = 2'd2,
    ST_LATCH = 2'd3
  } ocp_state_e;
endpackage

// File: rtl/ocp_sat_cnt.sv
module ocp_sat_cnt #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ocp_seq_fsm.sv
module ocp_seq_fsm
  import ocp_seq_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned SKIP_LEN  = 8,
  parameter int unsigned WATCH_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             lim_det_i,
  input  logic             fault_clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output ocp_state_e       state_o,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o
);
  localparam int unsigned LAST_SKIP  = SKIP_LEN - 1;
  localparam int unsigned LAST_WATCH = SKIP_LEN + WATCH_LEN - 1;
  localparam logic [CNT_W-1:0] SKIP_END  = CNT_W'(LAST_SKIP);
  localparam logic [CNT_W-1:0] WATCH_END = CNT_W'(LAST_WATCH);

  ocp_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    if (fault_clr_i || !en_i) begin
      state_d   = ST_IDLE;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (lim_det_i) begin
            state_d   = ST_SKIP;  // this cycle is cycle 0
            cnt_inc_o = 1'b1;
          end else begin
            cnt_clr_o = 1'b1;
          end
        end
        ST_SKIP: begin
          cnt_inc_o = 1'b1;       // trips here only skip pulses
          if (cnt_i == SKIP_END) state_d = ST_WATCH;
        end
        ST_WATCH: begin
          if (lim_det_i) begin
            state_d = ST_LATCH;
          end else if (cnt_i == WATCH_END) begin
            state_d   = ST_IDLE;
            cnt_clr_o = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        ST_LATCH: state_d = ST_LATCH;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ocp_drive_gate.sv
module ocp_drive_gate (
  input  logic en_i,
  input  logic lim_det_i,
  input  logic latched_i,
  output logic hs_inhibit_o,
  output logic pgood_drop_o
);
  assign hs_inhibit_o = latched_i | (en_i & lim_det_i);
  assign pgood_drop_o = latched_i;
endmodule

// File: rtl/ocp_skip_latch.sv
module ocp_skip_latch
  import ocp_seq_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned SKIP_LEN  = 8,
  parameter int unsigned WATCH_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lim_det_i,
  input  logic fault_clr_i,
  output logic hs_inhibit_o,
  output logic fault_latched_o,
  output logic pgood_drop_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_clr, cnt_inc;
  ocp_state_e       state_q;
  logic             latched;

  ocp_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt_q)
  );

  ocp_seq_fsm #(
    .CNT_W     (CNT_W),
    .SKIP_LEN  (SKIP_LEN),
    .WATCH_LEN (WATCH_LEN)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .lim_det_i   (lim_det_i),
    .fault_clr_i (fault_clr_i),
    .cnt_i       (cnt_q),
    .state_o     (state_q),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc)
  );

  assign latched = (state_q == ST_LATCH);

  ocp_drive_gate u_gate (
    .en_i         (en_i),
    .lim_det_i    (lim_det_i),
    .latched_i    (latched),
    .hs_inhibit_o (hs_inhibit_o),
    .pgood_drop_o (pgood_drop_o)
  );

  assign fault_latched_o = latched;
endmodule

// File: rtl/ocp_skip_latch_chk.sv
module ocp_skip_latch_chk #(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned SKIP_LEN  = 8,
  parameter int unsigned WATCH_LEN = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             lim_det_i,
  input logic             fault_clr_i,
  input logic             hs_inhibit_o,
  input logic             fault_latched_o,
  input logic             pgood_drop_o,
  input logic [CNT_W-1:0] cnt_q
);
  localparam int unsigned TOTAL = SKIP_LEN + WATCH_LEN;

  assert_skip_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lim_det_i) |-> hs_inhibit_o);

  assert_quiet_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_latched_o) |-> ($past(cnt_q) >= CNT_W'(SKIP_LEN)));

  assert_latch_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_latched_o) |-> $past(en_i && lim_det_i));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TOTAL));

  assert_latch_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_latched_o |-> (pgood_drop_o && hs_inhibit_o));

  assert_latch_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_latched_o && en_i && !fault_clr_i) |=> fault_latched_o);

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_clr_i || !en_i) |=> (!fault_latched_o && cnt_q == '0));

  assert_disabled_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !fault_latched_o) |-> !hs_inhibit_o);
endmodule

bind ocp_skip_latch ocp_skip_latch_chk #(
  .CNT_W     (CNT_W),
  .SKIP_LEN  (SKIP_LEN),
  .WATCH_LEN (WATCH_LEN)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .en_i            (en_i),
  .lim_det_i       (lim_det_i),
  .fault_clr_i     (fault_clr_i),
  .hs_inhibit_o    (hs_inhibit_o),
  .fault_latched_o (fault_latched_o),
  .pgood_drop_o    (pgood_drop_o),
  .cnt_q           (cnt_q)
);

// File: tb/ocp_skip_latch_tb.sv
module ocp_skip_latch_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, lim = 1'b0, clr = 1'b0;
  logic inh, lat, drop;
  int   n_chk = 0, n_fail = 0;
  int   cyc_cnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  ocp_skip_latch u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .en_i            (en),
    .lim_det_i       (lim),
    .fault_clr_i     (clr),
    .hs_inhibit_o    (inh),
    .fault_latched_o (lat),
    .pgood_drop_o    (drop)
  );

  // row: {en, lim, clr, exp_inhibit, exp_latched, req[2:0]}
  localparam int NV = 57;
  localparam logic [7:0] VEC [NV] = '{
    8'b11010_001, 8'b11010_010,                                         // r0-1
    8'b10000_010, 8'b10000_010, 8'b10000_010, 8'b10000_010, 8'b10000_010, // r2-6
    8'b11010_010,                                                        // r7 last skip cycle
    8'b10000_100, 8'b10000_100, 8'b10000_100, 8'b10000_100,
    8'b10000_100, 8'b10000_100, 8'b10000_100, 8'b10000_100,              // r8-15
    8'b11010_100,                                                        // r16 auto-cleared
    8'b10000_011, 8'b10000_011, 8'b10000_011, 8'b10000_011,
    8'b10000_011, 8'b10000_011, 8'b10000_011,                            // r17-23
    8'b11010_011,                                                        // r24 first watch cycle
    8'b10011_101, 8'b10011_110, 8'b10111_110,                            // r25-27 latched, clear
    8'b11010_110,                                                        // r28 released, new trip
    8'b10000_011, 8'b10000_011, 8'b10000_011, 8'b10000_011, 8'b10000_011,
    8'b10000_011, 8'b10000_011, 8'b10000_011, 8'b10000_011, 8'b10000_011,
    8'b10000_011, 8'b10000_011, 8'b10000_011, 8'b10000_011,              // r29-42
    8'b11010_011, 8'b10011_011,                                          // r43 last watch cycle
    8'b00011_110, 8'b10000_110,                                          // r45-46 enable drop
    8'b01000_111,                                                        // r47 trip while disabled
    8'b10000_111, 8'b10000_111, 8'b10000_111, 8'b10000_111,
    8'b10000_111, 8'b10000_111, 8'b10000_111,                            // r48-54
    8'b11010_111, 8'b10000_111                                           // r55-56
  };

  function automatic string req_name(input logic [2:0] r);
    case (r)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at t=%0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic l, input logic c);
    @(negedge clk);
    en = e; lim = l; clr = c;
    #1;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 5000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual %0d cycles expected at most 5000", cyc_cnt);
        report();
      end
    end
  end

  initial begin
    // R8: reset state
    repeat (2) @(negedge clk);
    #1;
    chk(inh, 1'b0, "R8", "inhibit in reset");
    chk(lat, 1'b0, "R8", "latched in reset");
    chk(drop, 1'b0, "R8", "pgood drop in reset");
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7], VEC[i][6], VEC[i][5]);
      chk(inh,  VEC[i][4], req_name(VEC[i][2:0]), $sformatf("inhibit row %0d", i));
      chk(lat,  VEC[i][3], req_name(VEC[i][2:0]), $sformatf("latched row %0d", i));
      chk(drop, VEC[i][3], req_name(VEC[i][2:0]), $sformatf("pgood drop row %0d", i));
    end

    // Let the running sequence expire
    repeat (20) step(1'b1, 1'b0, 1'b0);
    chk(lat, 1'b0, "R4", "idle after quiet run");

    // R7: enable drop in mid-sequence abandons it
    step(1'b1, 1'b1, 1'b0);                    // cycle 0
    repeat (3) step(1'b1, 1'b0, 1'b0);         // cycles 1-3
    step(1'b0, 1'b0, 1'b0);                    // cycle 4, disabled
    repeat (4) step(1'b1, 1'b0, 1'b0);         // old cycles 5-8
    step(1'b1, 1'b1, 1'b0);                    // old cycle 9: must be fresh trip
    chk(inh, 1'b1, "R7", "inhibit on fresh trip");
    step(1'b1, 1'b0, 1'b0);
    chk(lat, 1'b0, "R7", "no latch after abandoned sequence");
    repeat (20) step(1'b1, 1'b0, 1'b0);

    // R8: asynchronous reset while latched
    step(1'b1, 1'b1, 1'b0);
    repeat (7) step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);                    // cycle 8
    step(1'b1, 1'b0, 1'b0);
    chk(lat, 1'b1, "R3", "latched before reset");
    #4 rst_ni = 1'b0;
    #1;
    chk(lat, 1'b0, "R8", "latched after async reset");
    chk(drop, 1'b0, "R8", "pgood drop after async reset");
    chk(inh, 1'b0, "R8", "inhibit after async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b1, 1'b0, 1'b0);
    chk(lat, 1'b0, "R8", "latched after reset release");

    report();
  end
endmodule